// File: doc/BRIEF.md
# Message-Signalled Interrupt File

This block is the interrupt file of one hart for message-signalled interrupts. Each interrupt identity has an enable bit and a pending bit. A device raises an interrupt by writing the identity number as a message; the block sets that identity's pending bit. Software configures and services the file through a register port that works by masked read-modify-write. Every access returns the old value of the register it selects.

The registers are a delivery enable, a priority threshold, a top-identity register and two packed word arrays, one for pending bits and one for enable bits. A combinational search finds the lowest-numbered identity that is both enabled and pending and lies below the threshold limit. That identity is the top identity. It drives the single interrupt output, which is registered. A write to the top register claims the top identity, which clears its pending bit.

Top module: `msi_intr_file`

## Requirements
- R1: After reset all enable bits, pending bits, the delivery register and the threshold register are zero. Every register reads zero and `irq_out` is low.
- R2: A message with an identity that is nonzero and below NUM_ID sets that identity's pending bit. A message with identity 0 or with an identity of NUM_ID or more changes nothing.
- R3: Identity 0 is never usable. Its enable bit and its pending bit always read zero, and writes to them are dropped.
- R4: A register access uses select 0 for delivery, 1 for threshold, 2 for top, 3 for a pending word and 4 for an enable word. It returns the old value on `reg_rdata` in the same cycle. Any nonzero `reg_wmask` makes the access a write, which stores (old & ~mask) | (data & mask).
- R5: In the arrays, bit b of word n is identity n*XLEN+b. A word index of NUM_ID/XLEN or more raises `reg_err` and changes no state.
- R6: Selects 5 to 7 raise `reg_err` and change no state.
- R7: The top register reads the lowest identity that is enabled, pending and below the search limit. It reads 0 when there is no such identity.
- R8: The search limit is the threshold value when that value is nonzero and no larger than NUM_ID. Otherwise the limit is NUM_ID. Only identities strictly below the limit take part in the search.
- R9: A write to the top register returns the old top identity and clears that identity's pending bit. When there is no top identity, the write changes nothing.
- R10: `irq_out` is a register. At each clock edge it loads the result of testing whether the delivery register is nonzero and a top identity exists. A state change therefore shows on `irq_out` one cycle later.
- R11: When a message and a register write fall in the same cycle, the message's pending set is applied after the register update, so the message wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A message write is present this cycle |
| msg_id | input | MSG_W | Identity number carried by the message |
| reg_valid | input | 1 | A register access is present this cycle |
| reg_sel | input | 3 | Register select code |
| reg_index | input | WIX_W | Word index for the pending and enable arrays |
| reg_wdata | input | XLEN | Write data |
| reg_wmask | input | XLEN | Write mask; zero means a plain read |
| reg_rdata | output | XLEN | Old value of the selected register |
| reg_err | output | 1 | The access is rejected |
| irq_out | output | 1 | External interrupt request |

## Verification
Read data and the error flag are combinational. They are due in the same cycle as the access, so the bench samples them 2 ns after it drives the request and before the edge that commits the write. Register state and pending bits change at that edge, and the next access reads the new values. `irq_out` lags by one more edge. Each interrupt check therefore first confirms that the output still holds its old level at the negative edge straight after the change, and then confirms the new level one cycle later.

// File: rtl/msi_intr_file.sv
module msi_intr_file #(
  parameter int NUM_ID = 64,
  parameter int XLEN   = 32,
  parameter int MSG_W  = 32,
  parameter int WIX_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [MSG_W-1:0] msg_id,
  input  logic             reg_valid,
  input  logic [2:0]       reg_sel,
  input  logic [WIX_W-1:0] reg_index,
  input  logic [XLEN-1:0]  reg_wdata,
  input  logic [XLEN-1:0]  reg_wmask,
  output logic [XLEN-1:0]  reg_rdata,
  output logic             reg_err,
  output logic             irq_out
);
  localparam int NWORDS = NUM_ID / XLEN;
  localparam int IDW    = $clog2(NUM_ID);
  localparam logic [2:0] SEL_DLV = 3'd0;
  localparam logic [2:0] SEL_THR = 3'd1;
  localparam logic [2:0] SEL_TOP = 3'd2;
  localparam logic [2:0] SEL_PND = 3'd3;
  localparam logic [2:0] SEL_ENA = 3'd4;

  logic [NUM_ID-1:0] en_q, pend_q, en_d, pend_d;
  logic [XLEN-1:0]   deliv_q, thr_q, deliv_d, thr_d;
  logic [XLEN-1:0]   pend_word, en_word;
  logic [IDW-1:0]    top_id;
  logic              irq_q, thr_ok, word_ok, is_arr, wr;

  function automatic logic [XLEN-1:0] rmw(input logic [XLEN-1:0] old,
                                          input logic [XLEN-1:0] d,
                                          input logic [XLEN-1:0] m);
    return (old & ~m) | (d & m);
  endfunction

  assign thr_ok  = (thr_q != '0) && (thr_q <= XLEN'(NUM_ID));
  assign word_ok = 32'(reg_index) < NWORDS;
  assign is_arr  = (reg_sel == SEL_PND) || (reg_sel == SEL_ENA);
  assign reg_err = reg_valid && ((reg_sel > SEL_ENA) || (is_arr && !word_ok));
  assign wr      = reg_valid && !reg_err && (reg_wmask != '0);
  assign irq_out = irq_q;

  always_comb begin
    top_id = '0;
    for (int i = NUM_ID - 1; i >= 1; i--)
      if (en_q[i] && pend_q[i] && (!thr_ok || XLEN'(i) < thr_q))
        top_id = IDW'(i);
  end

  always_comb begin
    pend_word = '0;
    en_word   = '0;
    for (int w = 0; w < NWORDS; w++)
      if (reg_index == WIX_W'(w)) begin
        pend_word = pend_q[w*XLEN +: XLEN];
        en_word   = en_q[w*XLEN +: XLEN];
      end
  end

  always_comb begin
    case (reg_sel)
      SEL_DLV: reg_rdata = deliv_q;
      SEL_THR: reg_rdata = thr_q;
      SEL_TOP: reg_rdata = XLEN'(top_id);
      SEL_PND: reg_rdata = word_ok ? pend_word : '0;
      SEL_ENA: reg_rdata = word_ok ? en_word : '0;
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    pend_d  = pend_q;
    en_d    = en_q;
    deliv_d = deliv_q;
    thr_d   = thr_q;
    if (wr) begin
      case (reg_sel)
        SEL_DLV: deliv_d = rmw(deliv_q, reg_wdata, reg_wmask);
        SEL_THR: thr_d   = rmw(thr_q, reg_wdata, reg_wmask);
        SEL_TOP: if (top_id != '0) pend_d[top_id] = 1'b0;
        SEL_PND:
          for (int w = 0; w < NWORDS; w++)
            if (reg_index == WIX_W'(w))
              pend_d[w*XLEN +: XLEN] = rmw(pend_word, reg_wdata, reg_wmask);
        SEL_ENA:
          for (int w = 0; w < NWORDS; w++)
            if (reg_index == WIX_W'(w))
              en_d[w*XLEN +: XLEN] = rmw(en_word, reg_wdata, reg_wmask);
        default: ;
      endcase
    end
    if (msg_valid && msg_id != '0 && msg_id < MSG_W'(NUM_ID))
      pend_d[msg_id[IDW-1:0]] = 1'b1;
    pend_d[0] = 1'b0;
    en_d[0]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      pend_q  <= '0;
      deliv_q <= '0;
      thr_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      pend_q  <= pend_d;
      deliv_q <= deliv_d;
      thr_q   <= thr_d;
      irq_q   <= (deliv_q != '0) && (top_id != '0);
    end
  end
endmodule

module msi_intr_file_chk #(
  parameter int NUM_ID = 64,
  parameter int XLEN   = 32,
  parameter int MSG_W  = 32,
  parameter int IDW    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic [MSG_W-1:0]  msg_id,
  input logic              reg_valid,
  input logic [2:0]        reg_sel,
  input logic [XLEN-1:0]   reg_wmask,
  input logic              reg_err,
  input logic              irq_out,
  input logic [NUM_ID-1:0] en_q,
  input logic [NUM_ID-1:0] pend_q,
  input logic [XLEN-1:0]   deliv_q,
  input logic [IDW-1:0]    top_id
);
  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deliv_q != '0 && top_id != '0) |=> irq_out);
  // R10
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(deliv_q != '0 && top_id != '0) |=> !irq_out);
  // R7
  top_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_id != '0) |-> (en_q[top_id] && pend_q[top_id]));
  // R6
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_sel > 3'd4) |-> reg_err);
  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_err && !msg_valid)
      |=> ($stable(en_q) && $stable(pend_q) && $stable(deliv_q)));
  // R9
  claim_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !reg_err && reg_sel == 3'd2 && reg_wmask != '0 &&
     top_id != '0 && !msg_valid) |=> !pend_q[$past(top_id)]);
  // R2
  msg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_id != '0 && msg_id < MSG_W'(NUM_ID))
      |=> pend_q[$past(msg_id[IDW-1:0])]);
endmodule

bind msi_intr_file msi_intr_file_chk #(
  .NUM_ID(NUM_ID), .XLEN(XLEN), .MSG_W(MSG_W), .IDW($clog2(NUM_ID))
) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_id(msg_id),
  .reg_valid(reg_valid), .reg_sel(reg_sel), .reg_wmask(reg_wmask),
  .reg_err(reg_err), .irq_out(irq_out), .en_q(en_q), .pend_q(pend_q),
  .deliv_q(deliv_q), .top_id(top_id)
);

// File: tb/test_msi_intr_file.sv
module test_msi_intr_file;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        msg_valid;
  logic [31:0] msg_id;
  logic        reg_valid;
  logic [2:0]  reg_sel;
  logic [3:0]  reg_index;
  logic [31:0] reg_wdata, reg_wmask, reg_rdata;
  logic        reg_err, irq_out;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  msi_intr_file #(.NUM_ID(64), .XLEN(32), .MSG_W(32), .WIX_W(4)) i_msi_intr_file (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_id(msg_id),
    .reg_valid(reg_valid), .reg_sel(reg_sel), .reg_index(reg_index),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
    .reg_err(reg_err), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] sel, input logic [3:0] idx,
                     input logic [31:0] d, input logic [31:0] m,
                     output logic [31:0] rd, output logic er);
    reg_valid = 1'b1; reg_sel = sel; reg_index = idx; reg_wdata = d; reg_wmask = m;
    #2;
    rd = reg_rdata; er = reg_err;
    @(negedge clk);
    reg_valid = 1'b0; reg_wmask = '0; msg_valid = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [2:0] sel,
                           input logic [3:0] idx, input logic [31:0] exp);
    logic [31:0] v; logic e;
    acc(sel, idx, '0, '0, v, e);
    chk(req, v, exp);
  endtask

  task automatic wr_chk(input string req, input logic [2:0] sel, input logic [3:0] idx,
                        input logic [31:0] d, input logic [31:0] m, input logic [31:0] old);
    logic [31:0] v; logic e;
    acc(sel, idx, d, m, v, e);
    chk(req, v, old);
  endtask

  task automatic send_msg(input logic [31:0] id);
    msg_valid = 1'b1; msg_id = id;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'b0, irq_out}, 32'd0);
    expect_rd("R1 delivery", 3'd0, 4'd0, 32'd0);
    expect_rd("R1 threshold", 3'd1, 4'd0, 32'd0);
    expect_rd("R1 top", 3'd2, 4'd0, 32'd0);
    expect_rd("R1 pend w0", 3'd3, 4'd0, 32'd0);
    expect_rd("R1 pend w1", 3'd3, 4'd1, 32'd0);
    expect_rd("R1 en w0", 3'd4, 4'd0, 32'd0);
    expect_rd("R1 en w1", 3'd4, 4'd1, 32'd0);
  endtask

  task automatic t_msg;
    send_msg(32'd5);
    expect_rd("R2 set id5", 3'd3, 4'd0, 32'h20);
    send_msg(32'd0);
    send_msg(32'd64);
    send_msg(32'd200);
    expect_rd("R2 ignored w0", 3'd3, 4'd0, 32'h20);
    expect_rd("R2 ignored w1", 3'd3, 4'd1, 32'h0);
    send_msg(32'd40);
    send_msg(32'd63);
    expect_rd("R2 R5 w1 bits", 3'd3, 4'd1, 32'h8000_0100);
  endtask

  task automatic t_id0;
    wr_chk("R4 en w0 old", 3'd4, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    expect_rd("R3 en bit0", 3'd4, 4'd0, 32'hFFFF_FFFE);
    wr_chk("R4 pend w0 old", 3'd3, 4'd0, 32'h1, 32'h1, 32'h20);
    expect_rd("R3 pend bit0", 3'd3, 4'd0, 32'h20);
    wr_chk("R4 en w1 old", 3'd4, 4'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
  endtask

  task automatic t_rmw;
    wr_chk("R4 delivery old", 3'd0, 4'd0, 32'hA5, 32'h0F, 32'h0);
    expect_rd("R4 delivery masked", 3'd0, 4'd0, 32'h05);
  endtask

  task automatic t_err;
    logic [31:0] v; logic e;
    acc(3'd4, 4'd2, 32'h0, 32'hFFFF_FFFF, v, e);
    chk("R5 index err", {31'b0, e}, 32'd1);
    expect_rd("R5 en w0 kept", 3'd4, 4'd0, 32'hFFFF_FFFE);
    expect_rd("R5 en w1 kept", 3'd4, 4'd1, 32'hFFFF_FFFF);
    acc(3'd6, 4'd0, 32'h0, 32'hFFFF_FFFF, v, e);
    chk("R6 sel err", {31'b0, e}, 32'd1);
    expect_rd("R6 delivery kept", 3'd0, 4'd0, 32'h05);
    acc(3'd3, 4'd1, 32'h0, 32'h0, v, e);
    chk("R5 index ok", {31'b0, e}, 32'd0);
  endtask

  task automatic t_top;
    expect_rd("R7 top lowest", 3'd2, 4'd0, 32'd5);
    wr_chk("R7 disable id5", 3'd4, 4'd0, 32'h0, 32'h20, 32'hFFFF_FFFE);
    expect_rd("R7 top skips disabled", 3'd2, 4'd0, 32'd40);
    wr_chk("R7 enable id5", 3'd4, 4'd0, 32'h20, 32'h20, 32'hFFFF_FFDE);
    wr_chk("R8 thr write", 3'd1, 4'd0, 32'd5, 32'hFFFF_FFFF, 32'd0);
    expect_rd("R8 thr5 top", 3'd2, 4'd0, 32'd0);
    wr_chk("R8 thr6", 3'd1, 4'd0, 32'd6, 32'hFFFF_FFFF, 32'd5);
    expect_rd("R8 thr6 top", 3'd2, 4'd0, 32'd5);
    wr_chk("R8 thr65", 3'd1, 4'd0, 32'd65, 32'hFFFF_FFFF, 32'd6);
    expect_rd("R8 thr65 full", 3'd2, 4'd0, 32'd5);
    wr_chk("R8 thr0", 3'd1, 4'd0, 32'd0, 32'hFFFF_FFFF, 32'd65);
  endtask

  task automatic t_claim_irq;
    chk("R10 irq high", {31'b0, irq_out}, 32'd1);
    wr_chk("R9 claim id5", 3'd2, 4'd0, 32'h0, 32'h1, 32'd5);
    expect_rd("R9 pend cleared", 3'd3, 4'd0, 32'h0);
    expect_rd("R9 next top", 3'd2, 4'd0, 32'd40);
    wr_chk("R8 thr40", 3'd1, 4'd0, 32'd40, 32'hFFFF_FFFF, 32'd0);
    chk("R10 irq lag", {31'b0, irq_out}, 32'd1);
    @(negedge clk);
    chk("R10 irq low", {31'b0, irq_out}, 32'd0);
    expect_rd("R8 thr40 top", 3'd2, 4'd0, 32'd0);
    wr_chk("R8 thr41", 3'd1, 4'd0, 32'd41, 32'hFFFF_FFFF, 32'd40);
    expect_rd("R8 thr41 top", 3'd2, 4'd0, 32'd40);
    wr_chk("R8 thr0 again", 3'd1, 4'd0, 32'd0, 32'hFFFF_FFFF, 32'd41);
    wr_chk("R9 claim id40", 3'd2, 4'd0, 32'h0, 32'h1, 32'd40);
    wr_chk("R9 claim id63", 3'd2, 4'd0, 32'h0, 32'h1, 32'd63);
    expect_rd("R9 none left", 3'd2, 4'd0, 32'd0);
    wr_chk("R9 empty claim", 3'd2, 4'd0, 32'h0, 32'h1, 32'd0);
    expect_rd("R9 pend w1 clear", 3'd3, 4'd1, 32'h0);
    chk("R10 irq idle", {31'b0, irq_out}, 32'd0);
  endtask

  task automatic t_deliv;
    send_msg(32'd3);
    chk("R10 irq not yet", {31'b0, irq_out}, 32'd0);
    @(negedge clk);
    chk("R10 irq from msg", {31'b0, irq_out}, 32'd1);
    wr_chk("R10 delivery off", 3'd0, 4'd0, 32'h0, 32'hFFFF_FFFF, 32'h05);
    chk("R10 irq hold", {31'b0, irq_out}, 32'd1);
    @(negedge clk);
    chk("R10 irq gated", {31'b0, irq_out}, 32'd0);
    expect_rd("R10 top still", 3'd2, 4'd0, 32'd3);
  endtask

  task automatic t_simul;
    msg_valid = 1'b1; msg_id = 32'd7;
    wr_chk("R11 old pend", 3'd3, 4'd0, 32'h0, 32'hFFFF_FFFF, 32'h08);
    expect_rd("R11 message wins", 3'd3, 4'd0, 32'h80);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; msg_valid = 1'b0; msg_id = '0; reg_valid = 1'b0;
    reg_sel = '0; reg_index = '0; reg_wdata = '0; reg_wmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_msg();
    t_id0();
    t_rmw();
    t_err();
    t_top();
    t_claim_irq();
    t_deliv();
    t_simul();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule